// File: doc/BRIEF.md
# Segmented Piecewise-Linear Gamma Corrector

This block applies a single transfer curve to the red, green and blue components of a 12-bit pixel stream. The curve is held as 64 coefficient entries. Each entry covers one segment of a fixed, non-uniform split of the input range 0 to 4095. The smallest inputs get unit-wide segments. Above those, each power-of-two octave is split into four equal segments. The top region is split into uniform segments 128 wide. For each component the block finds the segment, takes the input's offset inside it, and produces base plus slope times offset. The slope carries 8 fractional bits, and the result is clamped at full scale.

Software loads coefficients through a simple write port into a shadow table. A two-state bank controller tracks whether the shadow differs from the table in use. The states are `BK_CLEAN` (shadow equals the active table) and `BK_DIRTY` (at least one write since the last copy). The transition CLEAN→DIRTY happens on any write. The transition DIRTY→CLEAN happens on a frame-start pulse with no write in the same cycle, and that pulse copies the shadow into the active table. A frame-start pulse that coincides with a write still copies the pre-write shadow but keeps the controller in DIRTY. DIRTY with no frame start stays DIRTY. CLEAN with no write stays CLEAN. Pixels flow through a three-stage valid/ready pipeline that stalls as a whole under output back-pressure.

Top module: `gamma_pwl`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and both coefficient tables are all zero, so every input component maps to output 0.
- R2: An input x in 0..15 uses entry x with offset 0, so the output equals that entry's base.
- R3: An input x in 16..511 whose leading one is bit p (4..8) falls in a segment 2^(p-2) wide. It uses entry 16 + 4*(p-4) + x[p-1:p-2], and its offset is x[p-3:0].
- R4: An input x in 512..4095 uses entry 32 + x[11:7], with offset x[6:0] (segments 128 wide).
- R5: A coefficient word carries the slope in bits 27:16 and the base in bits 11:0, and all other bits are ignored. The output is base + ((offset × slope) >> 8).
- R6: A result above 4095 is clamped to 4095.
- R7: The red, green and blue components are each mapped independently through the same single table.
- R8: A coefficient write changes only the shadow table and has no effect on output pixels until a frame-start pulse.
- R9: A frame-start pulse in state `BK_DIRTY` copies the whole shadow table into the active table, and pixels accepted afterwards use the new curve.
- R10: A write in the same cycle as a frame-start pulse is not part of that copy. The controller stays in `BK_DIRTY`, so the next frame-start pulse commits that write.
- R11: With `out_ready` held high, a pixel accepted at one clock edge appears on the output after the third rising edge counted from that edge (latency 3 cycles).
- R12: While `out_valid` is 1 and `out_ready` is 0, the output pixel stays stable and `in_ready` is 0. Pixels are never lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coefficient write strobe (writes the shadow table) |
| cfg_addr | input | 6 | Coefficient entry index |
| cfg_wdata | input | 32 | Coefficient word: slope 27:16, base 11:0 |
| frame_start | input | 1 | One-cycle pulse that commits the shadow table |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high together with in_valid |
| in_r | input | 12 | Input red component |
| in_g | input | 12 | Input green component |
| in_b | input | 12 | Input blue component |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_r | output | 12 | Corrected red component |
| out_g | output | 12 | Corrected green component |
| out_b | output | 12 | Corrected blue component |

## Verification
Several properties are checked on every cycle:
- the output is held during a stall;
- the active table is untouched in any cycle without a frame start;
- a frame start in the dirty state produces an exact shadow copy;
- a write always leaves the controller dirty;
- the decoded offset always lies inside its segment.

Other behaviour can only be shown by the bench scenarios, which compare output values with a model of the partition and the arithmetic:
- the actual segment boundaries and output values;
- clamping;
- the rule that shadow writes have no effect before a commit;
- the deferred commit of a write that coincides with a frame start;
- the exact three-cycle latency;
- ordering under random back-pressure.

// File: rtl/gamma_pwl_pkg.sv
package gamma_pwl_pkg;
    localparam int DW    = 12;               // component width
    localparam int S0B   = 4;                // unit segments cover 0 .. 2^S0B-1
    localparam int MIDN  = 5;                // number of octave sectors
    localparam int SUBB  = 2;                // log2 of segments per octave
    localparam int TOPB  = S0B + MIDN;       // first bit of the uniform top region
    localparam int OFFW  = TOPB - SUBB;      // widest segment offset
    localparam int SHW   = $clog2(OFFW + 1);
    localparam int NSEG  = (1 << S0B) + MIDN * (1 << SUBB)
                         + (1 << (DW - OFFW)) - (1 << SUBB);
    localparam int IDXW  = $clog2(NSEG);
    localparam int SLW   = 12;               // slope width
    localparam int FRAC  = 8;                // slope fractional bits
    localparam int NCH   = 3;

    typedef struct packed {
        logic [SLW-1:0] slope;
        logic [DW-1:0]  base;
    } coef_t;

    typedef enum logic {
        BK_CLEAN = 1'b0,
        BK_DIRTY = 1'b1
    } bank_st_e;
endpackage

// File: rtl/gamma_seg_decode.sv
module gamma_seg_decode
    import gamma_pwl_pkg::*;
(
    input  logic [DW-1:0]   x,
    output logic [IDXW-1:0] idx,
    output logic [OFFW-1:0] off,
    output logic [SHW-1:0]  sh
);
    localparam int SEG_PER = 1 << SUBB;
    localparam int MID0    = 1 << S0B;
    localparam int TOP0    = MID0 + MIDN * SEG_PER - SEG_PER;

    always_comb begin
        idx = IDXW'(x[S0B-1:0]);
        off = '0;
        sh  = '0;
        // ascending scan: the highest set bit in the octave region wins
        for (int p = S0B; p < TOPB; p++) begin
            if (x[p]) begin
                idx = IDXW'(MID0 + (p - S0B) * SEG_PER
                            + ((int'(x) >> (p - SUBB)) & (SEG_PER - 1)));
                off = OFFW'(int'(x) & ((1 << (p - SUBB)) - 1));
                sh  = SHW'(p - SUBB);
            end
        end
        if ((x >> TOPB) != '0) begin
            idx = IDXW'(TOP0 + (int'(x) >> OFFW));
            off = x[OFFW-1:0];
            sh  = SHW'(OFFW);
        end
    end
endmodule

// File: rtl/gamma_coef_bank.sv
module gamma_coef_bank
    import gamma_pwl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDXW-1:0]   addr,
    input  coef_t             wcoef,
    input  logic              frame_start,
    output coef_t [NSEG-1:0]  act_tbl
);
    coef_t [NSEG-1:0] shadow;
    coef_t [NSEG-1:0] active;
    bank_st_e         st, st_nx;
    logic             commit;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= BK_CLEAN;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            BK_CLEAN: st_nx = we ? BK_DIRTY : BK_CLEAN;
            BK_DIRTY: st_nx = (frame_start && !we) ? BK_CLEAN : BK_DIRTY;
            default:  st_nx = BK_DIRTY;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (st)
            BK_CLEAN: commit = 1'b0;
            BK_DIRTY: commit = frame_start;
            default:  commit = frame_start;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (we) begin
            shadow[addr] <= wcoef;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
        end else if (commit) begin
            active <= shadow;
        end
    end

    assign act_tbl = active;

    // R8
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(active));

    // R9
    commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && st == BK_DIRTY) |=> (active == $past(shadow)));

    // R10
    write_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (st == BK_DIRTY));
endmodule

// File: rtl/gamma_pipe.sv
module gamma_pipe
    import gamma_pwl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  coef_t [NSEG-1:0]  act_tbl,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [NCH*DW-1:0] in_pix,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [NCH*DW-1:0] out_pix
);
    localparam int PW = OFFW + SLW;

    logic adv;
    logic v1, v2, v3;

    assign adv       = !v3 || out_ready;
    assign in_ready  = adv;
    assign out_valid = v3;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
            v3 <= 1'b0;
        end else if (adv) begin
            v1 <= in_valid;
            v2 <= v1;
            v3 <= v2;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [DW-1:0]   xin;
        logic [IDXW-1:0] dec_idx;
        logic [OFFW-1:0] dec_off;
        logic [SHW-1:0]  dec_sh;
        logic [IDXW-1:0] s1_idx;
        logic [OFFW-1:0] s1_off;
        logic [DW-1:0]   s2_base;
        logic [PW-1:0]   s2_prod;
        logic [DW-1:0]   s3_val;
        coef_t           ent;
        logic [DW:0]     sum;

        assign xin = in_pix[c*DW +: DW];

        gamma_seg_decode u_dec (
            .x   (xin),
            .idx (dec_idx),
            .off (dec_off),
            .sh  (dec_sh)
        );

        assign ent = act_tbl[s1_idx];
        assign sum = {1'b0, s2_base} + (DW+1)'(s2_prod >> FRAC);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_idx  <= '0;
                s1_off  <= '0;
                s2_base <= '0;
                s2_prod <= '0;
                s3_val  <= '0;
            end else if (adv) begin
                s1_idx  <= dec_idx;
                s1_off  <= dec_off;
                s2_base <= ent.base;
                s2_prod <= PW'(s1_off) * PW'(ent.slope);
                s3_val  <= sum[DW] ? {DW{1'b1}} : sum[DW-1:0];
            end
        end

        assign out_pix[c*DW +: DW] = s3_val;

        // R3
        off_in_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> ((dec_off >> dec_sh) == '0));
    end

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));
endmodule

// File: rtl/gamma_pwl.sv
module gamma_pwl
    import gamma_pwl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [5:0]      cfg_addr,
    input  logic [31:0]     cfg_wdata,
    input  logic            frame_start,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [11:0]     in_r,
    input  logic [11:0]     in_g,
    input  logic [11:0]     in_b,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [11:0]     out_r,
    output logic [11:0]     out_g,
    output logic [11:0]     out_b
);
    coef_t [NSEG-1:0]  act_tbl;
    coef_t             wcoef;
    logic [NCH*DW-1:0] in_pix;
    logic [NCH*DW-1:0] out_pix;
    logic              cfg_unused;

    assign wcoef      = {cfg_wdata[16 +: SLW], cfg_wdata[DW-1:0]};
    assign cfg_unused = ^{cfg_wdata[31:16+SLW], cfg_wdata[15:DW]};
    assign in_pix     = {in_b, in_g, in_r};

    gamma_coef_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wcoef       (wcoef),
        .frame_start (frame_start),
        .act_tbl     (act_tbl)
    );

    gamma_pipe u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_tbl   (act_tbl),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_pix   (out_pix)
    );

    assign out_r = out_pix[0*DW +: DW];
    assign out_g = out_pix[1*DW +: DW];
    assign out_b = out_pix[2*DW +: DW];
endmodule

// File: tb/gamma_pwl_tb.sv
`timescale 1ns/1ps
module gamma_pwl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_r = '0, in_g = '0, in_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [11:0] out_r, out_g, out_b;

    int checks = 0;
    int errors = 0;
    int rmode = 0;
    bit done = 1'b0;

    int seg_start[64];
    int seg_w[64];
    logic [23:0] shadow_m[64];
    logic [23:0] active_m[64];
    int    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    gamma_pwl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
        .in_ready(in_ready), .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_r(out_r),
        .out_g(out_g), .out_b(out_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int gref(input int x);
        int r;
        r = 0;
        for (int i = 0; i < 64; i++) begin
            if (x >= seg_start[i] && x < seg_start[i] + seg_w[i]) begin
                r = int'(active_m[i][11:0])
                  + (((x - seg_start[i]) * int'(active_m[i][23:12])) >> 8);
            end
        end
        if (r > 4095) r = 4095;
        return r;
    endfunction

    task automatic set_ready();
        if (rmode == 1) out_ready = ($urandom % 4) != 0;
        else            out_ready = (rmode == 0);
    endtask

    task automatic send(input int r, input int g, input int b, input string t);
        bit go;
        go = 1'b0;
        while (!go) begin
            @(negedge clk);
            set_ready();
            in_valid = 1'b1;
            in_r = 12'(r); in_g = 12'(g); in_b = 12'(b);
            #0.5;
            go = in_ready;
            if (go) begin
                exp_q.push_back(gref(r)); exp_q.push_back(gref(g));
                exp_q.push_back(gref(b)); tag_q.push_back(t);
            end
            @(posedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            set_ready();
            in_valid = 1'b0;
        end
    endtask

    task automatic drain();
        while (tag_q.size() != 0) idle(1);
        idle(2);
    endtask

    task automatic wr(input int a, input logic [31:0] d, input bit fs);
        @(negedge clk);
        set_ready();
        in_valid = 1'b0;
        cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d; frame_start = fs;
        if (fs) for (int i = 0; i < 64; i++) active_m[i] = shadow_m[i];
        shadow_m[a] = {d[27:16], d[11:0]};
        @(negedge clk);
        cfg_we = 1'b0; frame_start = 1'b0;
    endtask

    task automatic fstart();
        @(negedge clk);
        in_valid = 1'b0;
        frame_start = 1'b1;
        for (int i = 0; i < 64; i++) active_m[i] = shadow_m[i];
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    // output monitor: compares every transferred pixel in order
    initial begin
        forever begin
            @(negedge clk);
            #0.5;
            if (rst_n && out_valid && out_ready) begin
                if (tag_q.size() == 0) begin
                    chk(1'b0, "R12 unexpected pixel", int'(out_r), -1);
                end else begin
                    string t;
                    int er, eg, eb;
                    t = tag_q.pop_front();
                    er = exp_q.pop_front(); eg = exp_q.pop_front(); eb = exp_q.pop_front();
                    chk(int'(out_r) == er, {t, " red"},   int'(out_r), er);
                    chk(int'(out_g) == eg, {t, " green"}, int'(out_g), eg);
                    chk(int'(out_b) == eb, {t, " blue"},  int'(out_b), eb);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] hr, hg, hb;
        int k;
        void'($urandom(32'h5EED_0C0F));
        for (int i = 0; i < 16; i++) begin seg_start[i] = i; seg_w[i] = 1; end
        k = 16;
        for (int s = 1; s <= 5; s++) begin
            for (int j = 0; j < 4; j++) begin
                seg_w[k] = 1 << (s + 1);
                seg_start[k] = (16 << (s - 1)) + j * seg_w[k];
                k++;
            end
        end
        for (int j = 0; j < 28; j++) begin seg_start[k] = 512 + j * 128; seg_w[k] = 128; k++; end
        for (int i = 0; i < 64; i++) begin shadow_m[i] = '0; active_m[i] = '0; end

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        rmode = 0;
        send(100, 2000, 4095, "R1 zero table");
        drain();

        // R8 shadow writes invisible until a frame start (R5: upper and middle bits are garbage)
        for (int i = 0; i < 64; i++) wr(i, $urandom, 1'b0);
        send(7, 300, 3000, "R8 before commit");
        drain();
        fstart();

        // R11 latency
        idle(3);
        @(negedge clk);
        set_ready();
        in_valid = 1'b1; in_r = 12'd600; in_g = 12'd9; in_b = 12'd40;
        #0.5;
        exp_q.push_back(gref(600)); exp_q.push_back(gref(9));
        exp_q.push_back(gref(40)); tag_q.push_back("R11 pixel");
        @(posedge clk);
        @(negedge clk); in_valid = 1'b0; #0.5;
        chk(out_valid == 1'b0, "R11 cycle1", int'(out_valid), 0);
        @(negedge clk); #0.5;
        chk(out_valid == 1'b0, "R11 cycle2", int'(out_valid), 0);
        @(negedge clk); #0.5;
        chk(out_valid == 1'b1, "R11 cycle3", int'(out_valid), 1);
        drain();

        // R2 R3 R4 boundaries, R9 new curve in use
        send(0, 15, 5, "R2 R9 unit segments");
        send(16, 19, 20, "R3 sector1");
        send(31, 32, 63, "R3 sector edges");
        send(255, 256, 511, "R3 upper sectors");
        send(512, 640, 4095, "R4 top region");
        send(639, 1000, 2047, "R4 mid top");
        drain();

        // R5 R7 R12 random pixels under random back-pressure
        rmode = 1;
        for (int n = 0; n < 300; n++) begin
            if (n % 3 == 0) begin
                int x;
                x = $urandom % 4096;
                send(x, x, x, "R5 R7 same value");
            end else begin
                send($urandom % 4096, $urandom % 4096, $urandom % 4096, "R5 R12 random");
            end
            if ($urandom % 5 == 0) idle(1);
        end
        rmode = 0;
        drain();

        // R12 stall: output held, input blocked
        rmode = 2;
        send(17, 700, 3333, "R12 stall a");
        send(100, 200, 300, "R12 stall b");
        send(4000, 12, 520, "R12 stall c");
        idle(1);
        #0.5;
        hr = out_r; hg = out_g; hb = out_b;
        for (int c = 0; c < 4; c++) begin
            idle(1);
            #0.5;
            chk(in_ready == 1'b0, "R12 in_ready low", int'(in_ready), 0);
            chk(out_valid == 1'b1 && out_r == hr && out_g == hg && out_b == hb,
                "R12 output held", int'(out_r), int'(hr));
        end
        rmode = 1;
        drain();
        rmode = 0;

        // R6 saturation
        wr(63, 32'hFFFF_FFA0, 1'b0);
        wr(36, 32'h0080_0F00, 1'b0);
        fstart();
        send(4095, 4000, 512, "R6 clamp");
        drain();
        chk(gref(4095) == 4095, "R6 model clamp", gref(4095), 4095);

        // R10 write coinciding with frame start is deferred
        wr(5, 32'h0000_0123, 1'b0);
        fstart();
        wr(5, 32'h0000_0ABC, 1'b1);
        send(5, 5, 5, "R10 old value kept");
        drain();
        chk(active_m[5][11:0] == 12'h123, "R10 model", int'(active_m[5][11:0]), 'h123);
        fstart();
        send(5, 5, 5, "R10 committed later");
        drain();

        chk(tag_q.size() == 0, "R12 no lost pixel", tag_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule